// File: doc/BRIEF.md
# Length-Detecting Three-Wire Serial Receiver

This block receives write-only words on a three-wire serial link made of an enable line, a clock line and a data line, all sampled by the system clock. While the enable line is high, one data bit is taken on each falling edge of the serial clock. The receiver counts the bits and infers the word format from that count when the enable line drops. Three word lengths are legal: 18, 19 and 27 bits.

Every word begins with four port bits. A 19-bit word then carries a full 15-bit frequency value. An 18-bit word carries only the low 14 frequency bits. A 27-bit word adds a trailing control byte. Two things depend on the length: when each register is committed, and the values of the reference-select bit and the top frequency bit. The outputs drive the shared tuner register file. A mode input lets this receiver be parked while the other serial bus owns that register file.

Top module: `tw_word_rx`

## Requirements
- R1: After reset the outputs are as follows: port_bits = 0 and freq_word = 0. pump_hi = 1 and test_bits = 3'b001. ref_sel_a = 0 and ref_sel_b = 1. tune_off = 1.
- R2: A data bit is taken only on a falling serial-clock edge while the enable line is high. Serial-clock activity while the enable line is low changes no output.
- R3: The first bit of a word goes to port_bits[3], the second to port_bits[2], the third to port_bits[1] and the fourth to port_bits[0]. They load on the 5th rising serial-clock edge. A word of four bits or fewer leaves port_bits unchanged.
- R4: When an 18-bit word ends, freq_word takes its last 14 bits, MSB first, with bit 14 forced to 0. ref_sel_a is set to 1.
- R5: When a 19-bit word ends, freq_word takes its last 15 bits, MSB first, and ref_sel_a is cleared to 0.
- R6: In a 27-bit word, bits 5 to 19 load into freq_word, MSB first, on the 20th rising serial-clock edge. When the enable line falls, the last eight bits load the control outputs. Of these eight bits, the first is ignored. The rest, in order, are pump_hi, test_bits[2], test_bits[1], test_bits[0], ref_sel_a, ref_sel_b and tune_off.
- R7: pump_hi, test_bits, ref_sel_b and tune_off keep their values across 18-bit and 19-bit words. The one exception is described in R8.
- R8: The first 18-bit or 19-bit word after reset clears tune_off. This applies only if no 27-bit word has already been committed. Later 18-bit or 19-bit words leave tune_off as it is.
- R9: A word shorter than 18 bits changes neither freq_word nor any control output.
- R10: A word of 20 to 26 bits, or of more than 27 bits, commits nothing when the enable line falls. Its port bits and the frequency loaded at the 20th edge remain. The bit counter saturates at 31 and clears when the enable line rises.
- R11: While bus_sel is low, no input activity changes any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 1 selects this receiver; 0 parks it |
| sw_en | input | 1 | Enable (framing) line |
| sw_clk | input | 1 | Serial clock line |
| sw_dat | input | 1 | Serial data line |
| port_bits | output | 4 | Band-switch port outputs |
| freq_word | output | 15 | Programmable divider value |
| pump_hi | output | 1 | Charge pump high-current select |
| test_bits | output | 3 | Test mode field |
| ref_sel_a | output | 1 | Reference divider select A |
| ref_sel_b | output | 1 | Reference divider select B |
| tune_off | output | 1 | Tuning output disable |

## Verification
The hardest state to reach is the middle of a 27-bit word. At that point the ports and the frequency have already changed, but the control outputs have not. The bench reaches it by clocking single bits and comparing outputs right after the 5th and 20th rising edges, before the enable line drops. The one-time clearing of tune_off also depends on history. To cover it, the bench sends an 18-bit word straight after reset, then a 27-bit word that sets tune_off again, then another 18-bit word. Illegal lengths of 23 and 40 bits are framed to cover the commit-nothing and counter-saturation paths.

// File: rtl/tw_word_rx.sv
module tw_word_rx #(
  parameter int PORT_W = 4,
  parameter int FREQ_W = 15,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              sw_en,
  input  logic              sw_clk,
  input  logic              sw_dat,
  output logic [PORT_W-1:0] port_bits,
  output logic [FREQ_W-1:0] freq_word,
  output logic              pump_hi,
  output logic [2:0]        test_bits,
  output logic              ref_sel_a,
  output logic              ref_sel_b,
  output logic              tune_off
);
  localparam int LEN_SHORT = PORT_W + FREQ_W - 1;
  localparam int LEN_MID   = PORT_W + FREQ_W;
  localparam int LEN_LONG  = LEN_MID + 8;
  localparam int SH_W      = LEN_LONG;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q, sck_q, first_pend;
  logic [CNT_W-1:0] bit_cnt;
  logic [SH_W-1:0]  sh;

  wire en_rise  = bus_sel &  sw_en  & ~en_q;
  wire en_fall  = bus_sel & ~sw_en  &  en_q;
  wire sck_rise = bus_sel &  sw_en  &  sw_clk & ~sck_q;
  wire sck_fall = bus_sel &  sw_en  & ~sw_clk &  sck_q;

  wire end_short = en_fall && bit_cnt == CNT_W'(LEN_SHORT);
  wire end_mid   = en_fall && bit_cnt == CNT_W'(LEN_MID);
  wire end_long  = en_fall && bit_cnt == CNT_W'(LEN_LONG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      en_q  <= sw_en;
      sck_q <= sw_clk;
      if (en_rise) begin
        bit_cnt <= '0;
        sh      <= '0;
      end else if (sck_fall) begin
        sh <= {sh[SH_W-2:0], sw_dat};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_bits  <= '0;
      freq_word  <= '0;
      pump_hi    <= 1'b1;
      test_bits  <= 3'b001;
      ref_sel_a  <= 1'b0;
      ref_sel_b  <= 1'b1;
      tune_off   <= 1'b1;
      first_pend <= 1'b1;
    end else begin
      if (sck_rise && bit_cnt == CNT_W'(PORT_W))
        port_bits <= sh[PORT_W-1:0];
      if (sck_rise && bit_cnt == CNT_W'(LEN_MID))
        freq_word <= sh[FREQ_W-1:0];
      if (end_short) begin
        freq_word <= {1'b0, sh[FREQ_W-2:0]};
        ref_sel_a <= 1'b1;
      end
      if (end_mid) begin
        freq_word <= sh[FREQ_W-1:0];
        ref_sel_a <= 1'b0;
      end
      if ((end_short || end_mid) && first_pend)
        tune_off <= 1'b0;
      if (end_long) begin
        pump_hi   <= sh[6];
        test_bits <= sh[5:3];
        ref_sel_a <= sh[2];
        ref_sel_b <= sh[1];
        tune_off  <= sh[0];
      end
      if (end_short || end_mid || end_long)
        first_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_word_rx_chk.sv
module tw_word_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        sw_en,
  input logic        sw_clk,
  input logic        en_q,
  input logic        sck_q,
  input logic [4:0]  bit_cnt,
  input logic [3:0]  port_bits,
  input logic [14:0] freq_word,
  input logic        pump_hi,
  input logic [2:0]  test_bits,
  input logic        ref_sel_a,
  input logic        ref_sel_b,
  input logic        tune_off
);
  wire fall_e = bus_sel & ~sw_en & en_q;
  wire rise_e = bus_sel &  sw_en & ~en_q;
  wire fall_c = bus_sel &  sw_en & ~sw_clk & sck_q;
  wire rise_c = bus_sel &  sw_en &  sw_clk & ~sck_q;

  p_port_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_c && bit_cnt == 5'd4) |=> $stable(port_bits));

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_e && bit_cnt == 5'd27) |=> $stable({pump_hi, test_bits, ref_sel_b}));

  p_short_freq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_e && bit_cnt < 5'd18) |=> $stable({freq_word, ref_sel_a, tune_off}));

  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == 5'd31 && fall_c) |=> bit_cnt == 5'd31);

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_e |=> bit_cnt == 5'd0);

  p_bus_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable({port_bits, freq_word, pump_hi, test_bits,
                          ref_sel_a, ref_sel_b, tune_off}));
endmodule

bind tw_word_rx tw_word_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .sw_en(sw_en), .sw_clk(sw_clk),
  .en_q(en_q), .sck_q(sck_q), .bit_cnt(bit_cnt), .port_bits(port_bits),
  .freq_word(freq_word), .pump_hi(pump_hi), .test_bits(test_bits),
  .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b), .tune_off(tune_off)
);

// File: tb/tw_word_rx_tb_top.sv
module tw_word_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam logic [53:0] VEC [NVEC] = '{
    {6'd18, 48'h0000_0002_ABCD},
    {6'd19, 48'h0000_0005_1234},
    {6'd27, 48'h0000_05A5_A5A5},
    {6'd18, 48'h0000_0001_5555},
    {6'd10, 48'h0000_0000_03C5},
    {6'd23, 48'h0000_007F_0F0F},
    {6'd40, 48'h00DE_ADBE_EF12},
    {6'd27, 48'h0000_0123_4567},
    {6'd4,  48'h0000_0000_000F}
  };

  logic clk = 0, rst_n = 0, bus_sel = 1, sw_en = 0, sw_clk = 0, sw_dat = 0;
  logic [3:0]  port_bits;
  logic [14:0] freq_word;
  logic pump_hi, ref_sel_a, ref_sel_b, tune_off;
  logic [2:0] test_bits;
  int n_chk = 0, n_fail = 0;

  logic [3:0] e_port; logic [14:0] e_freq; logic e_cp; logic [2:0] e_t;
  logic e_rsa, e_rsb, e_os, e_first;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_word_rx dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .sw_en(sw_en),
    .sw_clk(sw_clk), .sw_dat(sw_dat), .port_bits(port_bits), .freq_word(freq_word),
    .pump_hi(pump_hi), .test_bits(test_bits), .ref_sel_a(ref_sel_a),
    .ref_sel_b(ref_sel_b), .tune_off(tune_off));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " ports"}, 32'(port_bits), 32'(e_port));
    chk({tag, " freq"},  32'(freq_word), 32'(e_freq));
    chk({tag, " ctrl"},  32'({pump_hi, test_bits, ref_sel_a, ref_sel_b, tune_off}),
                         32'({e_cp, e_t, e_rsa, e_rsb, e_os}));
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sw_dat = b; sw_clk = 1; wait_n(2);
    sw_clk = 0; wait_n(2);
  endtask

  task automatic send_word(input int n, input logic [47:0] p);
    sw_en = 1; wait_n(2);
    for (int i = n - 1; i >= 0; i--) send_bit(p[i]);
    wait_n(1); sw_en = 0; wait_n(3);
  endtask

  task automatic model(input int n, input logic [47:0] p);
    if (!bus_sel) return;
    if (n >= 5)  e_port = p[n-1 -: 4];
    if (n >= 20) e_freq = p[n-5 -: 15];
    if (n == 18) begin e_freq = {1'b0, p[13:0]}; e_rsa = 1; if (e_first) e_os = 0; e_first = 0; end
    if (n == 19) begin e_freq = p[14:0]; e_rsa = 0; if (e_first) e_os = 0; e_first = 0; end
    if (n == 27) begin
      e_cp = p[6]; e_t = p[5:3]; e_rsa = p[2]; e_rsb = p[1]; e_os = p[0]; e_first = 0;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [26:0] w;
    e_port = 0; e_freq = 0; e_cp = 1; e_t = 3'b001; e_rsa = 0; e_rsb = 1; e_os = 1; e_first = 1;
    wait_n(3); rst_n = 1; wait_n(2);
    chk_all("R1 reset");

    for (int v = 0; v < NVEC; v++) begin
      send_word(int'(VEC[v][53:48]), VEC[v][47:0]);
      model(int'(VEC[v][53:48]), VEC[v][47:0]);
      chk_all($sformatf("R3 R4 R5 R6 R7 R8 R9 R10 vec%0d len%0d", v, VEC[v][53:48]));
    end

    // R2: clock activity with enable low
    for (int i = 0; i < 30; i++) send_bit(i[0]);
    chk_all("R2 idle clock");

    // R11: parked receiver
    bus_sel = 0;
    send_word(19, 48'h7_7777);
    chk_all("R11 bus off");
    bus_sel = 1; wait_n(2);

    // R6: mid-word observation of a 27-bit word
    w = 27'h6B3_C0DE;
    sw_en = 1; wait_n(2);
    for (int i = 26; i >= 22; i--) send_bit(w[i]);
    chk("R3 ports after 5th rise", 32'(port_bits), 32'(w[26:23]));
    chk("R6 freq before 20th rise", 32'(freq_word), 32'(e_freq));
    for (int i = 21; i >= 7; i--) send_bit(w[i]);
    chk("R6 freq at 20th rise", 32'(freq_word), 32'(w[22:8]));
    chk("R6 ctrl held mid-word", 32'({pump_hi, test_bits, ref_sel_a, ref_sel_b, tune_off}),
        32'({e_cp, e_t, e_rsa, e_rsb, e_os}));
    for (int i = 6; i >= 0; i--) send_bit(w[i]);
    wait_n(1); sw_en = 0; wait_n(3);
    model(27, 48'(w));
    chk_all("R6 end of long word");

    // R10: counter restarts after saturation
    send_word(35, 48'h5_5555_5555);
    model(35, 48'h5_5555_5555);
    send_word(19, 48'h2_468A);
    model(19, 48'h2_468A);
    chk_all("R10 R5 after saturation");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule